// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects five interrupt sources: two active-low external pins, two timer overflow pulses and one serial event. It decides which of them the CPU should service next. Each source passes a per-source enable and a global enable. Each source also carries a priority bit that places it at the low or the high level. Inside a level, a fixed index order breaks ties. The winner is shown to the CPU as a request, a level flag and a 16-bit vector address.

The CPU accepts the request with a one-cycle take pulse and signals the end of a handler with a one-cycle return pulse. On a take, the controller records that a service at the granted level is running. It also clears the source's latched flag if that source has one. A high-level request may interrupt a low-level handler. Nothing interrupts a high-level handler, and a low-level request never interrupts a low-level handler. A return pulse closes the innermost open level.

The enable and priority registers sit behind a byte-wide write port and a combinational read port.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, both registers read 0x00, no request is raised and neither service level is active.
- R2: While bit 7 of the enable register (global enable) is 0, `irq_req` stays low, whatever the per-source enable bits hold.
- R3: Source index i maps to bit i of both registers. The indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial. A source requests only while its enable bit is 1. Enable register bits 6..5 and priority register bits 7..5 always read 0. `reg_sel`=0 selects the enable register and 1 selects the priority register.
- R4: The vector of source index i is 0x0003 + 8*i. That gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R5: Among eligible sources at the same level, the lowest index wins.
- R6: A high-level request is raised while only a low-level service is active. No request is raised while a high-level service is active. A low-level request is not raised while a low-level service is active.
- R7: A return pulse ends the high-level service if one is active, and otherwise the low-level service. The other level is left unchanged.
- R8: With its type bit (`ext_edge_sel`) at 1, an external source latches a request on a falling edge of its pin. The request stays after the pin returns high and is cleared when that source is taken.
- R9: With its type bit at 0, an external request follows the pin while it is low. Nothing is latched, and a take does not remove it.
- R10: A timer overflow pulse latches a request, which is cleared when that source is taken.
- R11: The serial request is the OR of `ser_rx_flag` and `ser_tx_flag` and is not cleared by a take.
- R12: When any eligible source has its priority bit at 1, the winner is the lowest such index and `irq_hi` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n | input | 2 | External request pins, active low (bit 0 is external 0) |
| ext_edge_sel | input | 2 | Per-pin type: 1 falling-edge latched, 0 low-level |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 is timer 0) |
| ser_rx_flag | input | 1 | Serial receive flag (level) |
| ser_tx_flag | input | 1 | Serial transmit flag (level) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 enable register, 1 priority register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cpu_take | input | 1 | CPU accepts the presented request |
| cpu_reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | A request is presented |
| irq_hi | output | 1 | The presented request is high level |
| irq_vector | output | 16 | Vector address of the presented request |
| svc_hi | output | 1 | High-level service in progress |
| svc_lo | output | 1 | Low-level service in progress |

## Verification
The bench builds the block with its default parameters: two external/timer pairs plus the serial source, a vector base of 3 and a stride of 8. With all five sources held pending, it sweeps every enable mask against every priority mask, which makes 1024 combinations. Each combination is compared with a winner computed arithmetically in the bench. Directed sequences then cover nested take and return, flags clearing on a take, and edge versus level pin behaviour.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Register bit holding the global enable.
  localparam int GLB_EN_BIT = 7;

  // Lowest set bit of an 8-bit mask (0 when the mask is empty).
  function automatic int first_set(input logic [7:0] mask);
    int r;
    r = 0;
    for (int i = 7; i >= 0; i--) begin
      if (mask[i]) r = i;
    end
    return r;
  endfunction

  // Vector address for a source index.
  function automatic int unsigned vec_calc(input int unsigned idx,
                                           input int unsigned base,
                                           input int unsigned stride);
    return base + idx * stride;
  endfunction

endpackage

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int SRC_N = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             glb_en,
  output logic [SRC_N-1:0] src_en,
  output logic [SRC_N-1:0] src_hi
);
  import intc_pkg::*;

  logic unused_wbits;
  assign unused_wbits = ^wdata[GLB_EN_BIT-1:SRC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      src_en <= '0;
      src_hi <= '0;
    end else if (wr) begin
      if (sel) begin
        src_hi <= wdata[SRC_N-1:0];
      end else begin
        glb_en <= wdata[GLB_EN_BIT];
        src_en <= wdata[SRC_N-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[SRC_N-1:0] = src_hi;
    end else begin
      rdata[SRC_N-1:0]  = src_en;
      rdata[GLB_EN_BIT] = glb_en;
    end
  end

endmodule

// File: rtl/intc_flag.sv
// One request cell: either a latched flag (set by an event, cleared on
// take) or a transparent level, chosen per cycle by latch_mode.
module intc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_mode,
  input  logic set_evt,
  input  logic level_req,
  input  logic clr,
  output logic pend
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (!latch_mode) flag_q <= 1'b0;
    else if (set_evt)    flag_q <= 1'b1;
    else if (clr)        flag_q <= 1'b0;
  end

  assign pend = latch_mode ? flag_q : level_req;

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && set_evt) |=> flag_q);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag_q);

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int SRC_N = 5,
  localparam int IDX_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] pend,
  input  logic [SRC_N-1:0] src_en,
  input  logic [SRC_N-1:0] src_hi,
  input  logic             glb_en,
  input  logic             svc_hi,
  input  logic             svc_lo,
  output logic             req,
  output logic             req_hi,
  output logic [IDX_W-1:0] grant_idx,
  output logic [SRC_N-1:0] grant
);
  import intc_pkg::*;

  logic [SRC_N-1:0] elig, hi_set, lo_set, pick;
  logic hi_ok, lo_ok;

  always_comb begin
    elig   = pend & src_en & {SRC_N{glb_en}};
    hi_set = elig & src_hi;
    lo_set = elig & ~src_hi;
    hi_ok  = (|hi_set) && !svc_hi;
    lo_ok  = (|lo_set) && !svc_hi && !svc_lo;
    pick   = hi_ok ? hi_set : lo_set;
    req    = hi_ok || lo_ok;
    req_hi = hi_ok;
    grant_idx = IDX_W'(first_set(8'(pick)));
    grant  = req ? (SRC_N'(1) << grant_idx) : '0;
  end

  // R2
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !req);

  // R6
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi |-> !req);

  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ($countones(grant) == 1 && (grant & elig) == grant));

endmodule

// File: rtl/intc_nest.sv
module intc_nest (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic svc_hi,
  output logic svc_lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else if (take) begin
      if (take_hi) svc_hi <= 1'b1;
      else         svc_lo <= 1'b1;
    end else if (reti) begin
      if (svc_hi) svc_hi <= 1'b0;
      else        svc_lo <= 1'b0;
    end
  end

  // R7
  reti_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && svc_hi) |=> (!svc_hi && $stable(svc_lo)));

  // R7
  reti_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && !svc_hi) |=> (!svc_lo && !svc_hi));

  // R6
  lo_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_hi) |-> (!svc_lo && !svc_hi));

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int PAIR_N     = 2,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int SRC_N = 2 * PAIR_N + 1,
  localparam int IDX_W = $clog2(SRC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAIR_N-1:0] ext_pin_n,
  input  logic [PAIR_N-1:0] ext_edge_sel,
  input  logic [PAIR_N-1:0] tmr_ovf,
  input  logic              ser_rx_flag,
  input  logic              ser_tx_flag,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cpu_take,
  input  logic              cpu_reti,
  output logic              irq_req,
  output logic              irq_hi,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              svc_hi,
  output logic              svc_lo
);
  import intc_pkg::*;

  logic             glb_en;
  logic [SRC_N-1:0] src_en, src_hi, pend, grant, clr_vec;
  logic [SRC_N-1:0] set_evt, level_req, latch_mode;
  logic [IDX_W-1:0] grant_idx;
  logic [PAIR_N-1:0] pin_prev, pin_fall;
  logic take_ev;

  intc_regs #(.SRC_N(SRC_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .glb_en(glb_en), .src_en(src_en), .src_hi(src_hi)
  );

  // Falling-edge detection on the external pins (idle high).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= '1;
    else        pin_prev <= ext_pin_n;
  end
  assign pin_fall = pin_prev & ~ext_pin_n;

  assign take_ev = cpu_take && irq_req;
  assign clr_vec = take_ev ? grant : '0;

  // Source index: even = external, odd = timer, last = serial.
  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    if (i == SRC_N - 1) begin : g_ser
      assign latch_mode[i] = 1'b0;
      assign set_evt[i]    = 1'b0;
      assign level_req[i]  = ser_rx_flag | ser_tx_flag;
    end else if (i % 2 == 0) begin : g_ext
      assign latch_mode[i] = ext_edge_sel[i/2];
      assign set_evt[i]    = pin_fall[i/2];
      assign level_req[i]  = ~ext_pin_n[i/2];
    end else begin : g_tmr
      assign latch_mode[i] = 1'b1;
      assign set_evt[i]    = tmr_ovf[i/2];
      assign level_req[i]  = 1'b0;
    end

    intc_flag u_flag (
      .clk(clk), .rst_n(rst_n), .latch_mode(latch_mode[i]),
      .set_evt(set_evt[i]), .level_req(level_req[i]),
      .clr(clr_vec[i]), .pend(pend[i])
    );
  end

  intc_arbiter #(.SRC_N(SRC_N)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .src_en(src_en),
    .src_hi(src_hi), .glb_en(glb_en), .svc_hi(svc_hi), .svc_lo(svc_lo),
    .req(irq_req), .req_hi(irq_hi), .grant_idx(grant_idx), .grant(grant)
  );

  intc_nest u_nest (
    .clk(clk), .rst_n(rst_n), .take(take_ev), .take_hi(irq_hi),
    .reti(cpu_reti), .svc_hi(svc_hi), .svc_lo(svc_lo)
  );

  assign irq_vector = VEC_W'(vec_calc(32'(grant_idx), VEC_BASE, VEC_STRIDE));

  // R11
  ser_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rx_flag || ser_tx_flag) |-> pend[SRC_N-1]);

endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] ext_pin_n = 2'b11, ext_edge_sel = 2'b00, tmr_ovf = 2'b00;
  logic ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic cpu_take = 1'b0, cpu_reti = 1'b0;
  logic irq_req, irq_hi, svc_hi, svc_lo;
  logic [15:0] irq_vector;

  int checks = 0, errors = 0;

  prio_vec_intc dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_sel(ext_edge_sel),
    .tmr_ovf(tmr_ovf), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_take(cpu_take), .cpu_reti(cpu_reti), .irq_req(irq_req), .irq_hi(irq_hi),
    .irq_vector(irq_vector), .svc_hi(svc_hi), .svc_lo(svc_lo)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_take();
    cpu_take = 1'b1; step(); cpu_take = 1'b0;
  endtask

  task automatic pulse_reti();
    cpu_reti = 1'b1; step(); cpu_reti = 1'b0;
  endtask

  task automatic chk_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic sel, input logic [7:0] exp);
    reg_sel = sel;
    #1;
    chk_val(tag, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic expect_irq(input string tag, input bit req, input bit hi, input int idx);
    logic [15:0] ev;
    ev = 16'(3 + 8 * idx);
    checks++;
    if (irq_req !== req || (req && (irq_hi !== hi || irq_vector !== ev))) begin
      errors++;
      $display("FAIL %s: actual req=%0b hi=%0b vec=%h expected req=%0b hi=%0b vec=%h",
               tag, irq_req, irq_hi, irq_vector, req, hi, ev);
    end
  endtask

  function automatic int lowest(input int m);
    for (int i = 4; i >= 0; i--) if (m[i]) lowest = i;
    if (m == 0) lowest = 0;
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    expect_irq("R1 no request", 0, 0, 0);
    chk_val("R1 service idle", {14'd0, svc_hi, svc_lo}, 16'd0);
    chk_reg("R1 enable reg", 1'b0, 8'h00);
    chk_reg("R1 priority reg", 1'b1, 8'h00);

    // R3 readback masks
    wr_reg(1'b0, 8'hFF);
    chk_reg("R3 enable unused bits", 1'b0, 8'h9F);
    wr_reg(1'b1, 8'hFF);
    chk_reg("R3 priority unused bits", 1'b1, 8'h1F);

    // All five sources pending: level pins low, timers latched, serial high.
    ext_edge_sel = 2'b00;
    ext_pin_n = 2'b00;
    ser_rx_flag = 1'b1;
    tmr_ovf = 2'b11; step(); tmr_ovf = 2'b00;

    for (int en = 0; en < 32; en++) begin
      wr_reg(1'b0, 8'(en));
      expect_irq("R2 global off", 0, 0, 0);
      for (int pr = 0; pr < 32; pr++) begin
        int hs, idx;
        wr_reg(1'b1, 8'(pr));
        wr_reg(1'b0, 8'(8'h80 | en));
        hs  = en & pr;
        idx = (hs != 0) ? lowest(hs) : lowest(en);
        // R3 R4 R5 R12 sweep
        expect_irq("R3/R4/R5/R12 sweep", en != 0, hs != 0, idx);
      end
    end

    // Timers: latched, cleared on take (R10), low cannot nest low (R6).
    ext_pin_n = 2'b11;
    ser_rx_flag = 1'b0;
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h8A);
    expect_irq("R10 timer0 pending", 1, 0, 1);
    pulse_take();
    chk_val("R6 low service open", {14'd0, svc_hi, svc_lo}, 16'd1);
    expect_irq("R6 low blocks low", 0, 0, 0);
    pulse_reti();
    chk_val("R7 low closed", {14'd0, svc_hi, svc_lo}, 16'd0);
    expect_irq("R10 timer0 cleared, timer1 next", 1, 0, 3);
    pulse_take();
    pulse_reti();
    expect_irq("R10 timer1 cleared", 0, 0, 0);

    // Preemption and serial persistence.
    wr_reg(1'b1, 8'h10);
    wr_reg(1'b0, 8'h9F);
    tmr_ovf = 2'b01; step(); tmr_ovf = 2'b00;
    expect_irq("R10 timer0 latched", 1, 0, 1);
    pulse_take();
    ser_tx_flag = 1'b1;
    step();
    expect_irq("R6 high preempts low", 1, 1, 4);
    pulse_take();
    chk_val("R6 both levels open", {14'd0, svc_hi, svc_lo}, 16'd3);
    expect_irq("R6 nothing preempts high", 0, 0, 0);
    pulse_reti();
    chk_val("R7 return to low", {14'd0, svc_hi, svc_lo}, 16'd1);
    expect_irq("R11 serial kept after take", 1, 1, 4);
    ser_tx_flag = 1'b0;
    step();
    expect_irq("R11 serial follows flags", 0, 0, 0);
    pulse_reti();
    chk_val("R7 all closed", {14'd0, svc_hi, svc_lo}, 16'd0);

    // Edge-latched external 0.
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h81);
    ext_edge_sel = 2'b01;
    step();
    expect_irq("R8 idle pin", 0, 0, 0);
    ext_pin_n[0] = 1'b0; step();
    expect_irq("R8 falling edge latched", 1, 0, 0);
    ext_pin_n[0] = 1'b1; step();
    expect_irq("R8 held after pin high", 1, 0, 0);
    pulse_take();
    pulse_reti();
    expect_irq("R8 cleared on take", 0, 0, 0);

    // Level-mode external 1.
    wr_reg(1'b0, 8'h84);
    ext_pin_n[1] = 1'b0; step();
    expect_irq("R9 level low requests", 1, 0, 2);
    pulse_take();
    pulse_reti();
    expect_irq("R9 take does not clear level", 1, 0, 2);
    ext_pin_n[1] = 1'b1; step();
    expect_irq("R9 no latch after release", 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule